// File: doc/BRIEF.md
# Vector Element Step Sequencer

This block walks the element positions of one vector instruction. An instruction starts with a one-cycle `start` pulse that carries the vector length, a sub-vector size code, a vertical-first flag and a parallelism hint. The sequencer latches these values. While it is busy it presents up to `LANES` sub-element slots per cycle. Each slot carries an element index and a sub-vector index. The sub-vector index is the innermost counter. When it wraps, the element index advances. Each slot also has a flag that marks the first sub-element of a group, which tells downstream logic where to sample one predicate bit for the whole group.

In horizontal-first operation the instruction runs from the current position to the end of the vector over as many cycles as it needs. The counters then return to zero. In vertical-first operation the instruction takes exactly one busy cycle. It issues one batch of fixed size from the current position and leaves the counters where they were. The counters move forward only on an explicit step request that arrives while the sequencer is idle. The position is reported on three ports: source step, destination step and sub-vector step. A `done` output tells issue logic that the instruction is finishing.

Top module: `vstep_seq`

## Requirements
- R1: While reset is held and after it is released, `busy`, `done`, `slot_valid` and `slot_grp_first` are 0, and `srcstep`, `dststep` and `svstep` are 0.
- R2: A `start` pulse seen while idle makes `busy` 1 in the next cycle. A `start` seen while busy is ignored: the running instruction keeps its latched configuration and ends exactly as it would have without that pulse.
- R3: The sub-vector size is `cfg_subvl`+1, so codes 0, 1, 2 and 3 give 1 to 4. Valid slots always fill lanes from lane 0 upward with no gaps. Lane i holds the i-th sub-element after the current position, in flattened order element×size+sub, with the sub index innermost. Its element index is on `slot_elem[i*VL_W +: VL_W]` and its sub index is on `slot_sub[2*i +: 2]`.
- R4: `slot_grp_first[i]` is 1 exactly when lane i is valid and its sub index is 0.
- R5: In horizontal-first mode (`cfg_vfirst`=0), each busy cycle issues min(`LANES`, remaining) slots, starting from the current counters. `done` is 1 in the cycle whose batch contains the last sub-element of element VL-1. After that cycle `busy` is 0 and all three step outputs are 0.
- R6: With a vector length of 0, the instruction occupies one busy cycle with `done` 1 and no valid slot, in either mode.
- R7: In vertical-first mode the batch width is E = 1 when the hint is 0, and otherwise E = min(hint, `LANES`). The instruction is one busy cycle with `done` 1 that issues min(E, remaining) slots. The step outputs are unchanged afterwards.
- R8: A `step_req` seen while idle, when the last started instruction was vertical-first, advances the position by E sub-elements. If the new position would reach or pass the end of the vector, the position becomes 0 instead.
- R9: `step_req` is ignored while busy, when the last started instruction was horizontal-first, and in the same cycle as an accepted `start`.
- R10: When a vertical-first batch covers everything that remains, a single one-cycle instruction issues all remaining slots and ends with `done`. This is the same slots and cycle count that a horizontal-first run of the same vector produces.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an instruction with the cfg_* values |
| cfg_vl | input | VL_W | Vector length, 0 to MAXVL |
| cfg_subvl | input | 2 | Sub-vector size code (size = code+1) |
| cfg_vfirst | input | 1 | 1 selects vertical-first operation |
| cfg_hint | input | HINT_W | Parallelism hint, 0 means none |
| step_req | input | 1 | Explicit step request (vertical-first) |
| busy | output | 1 | An instruction is issuing this cycle |
| done | output | 1 | This cycle ends the instruction |
| slot_valid | output | LANES | Per-lane slot valid |
| slot_elem | output | LANES*VL_W | Per-lane element index |
| slot_sub | output | LANES*2 | Per-lane sub-vector index |
| slot_grp_first | output | LANES | Lane holds the first sub-element of a group |
| srcstep | output | VL_W | Current source element step |
| dststep | output | VL_W | Current destination element step |
| svstep | output | 2 | Current sub-vector step |

## Verification
Two collisions matter. The first is a step request and an instruction start arriving in the same idle cycle. The bench raises both on one edge after a vertical-first instruction. It then expects the new instruction's batch to begin at the old position, and the step ports to show no advance afterwards. The second is a step request that arrives in the one busy cycle of a vertical-first instruction. The bench judges it by the step ports being unchanged once `busy` falls. A `start` pulse injected in the middle of a long horizontal-first run is judged by the run's cycle count and slot contents, which must match an undisturbed run.

// File: rtl/vstep_pkg.sv
// Package vstep_pkg
// Shared widths and types for the element step sequencer.
// Assumes a sub-vector size of at most four, encoded as size-1 in two bits.
package vstep_pkg;
    localparam int SUB_W = 2;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_t;
endpackage

// File: rtl/vstep_inc.sv
// Module vstep_inc
// Advances an (element, sub-element) position by one sub-element.
// The sub index wraps after sub_last and then carries into the element.
// Assumes the element field is wide enough that an overshoot past the
// vector end is harmless; callers mask such positions.
module vstep_inc #(
    parameter int VL_W  = 7,
    parameter int SUB_W = 2
) (
    input  logic [VL_W-1:0]  in_elem,
    input  logic [SUB_W-1:0] in_sub,
    input  logic [SUB_W-1:0] sub_last,
    output logic [VL_W-1:0]  out_elem,
    output logic [SUB_W-1:0] out_sub
);
    // Step the sub index, carrying into the element index on wrap.
    always_comb begin
        if (in_sub == sub_last) begin
            out_sub  = '0;
            out_elem = in_elem + VL_W'(1);
        end else begin
            out_sub  = in_sub + SUB_W'(1);
            out_elem = in_elem;
        end
    end
endmodule

// File: rtl/vstep_width.sv
// Module vstep_width
// Derives the per-instruction batch width from mode and hint.
// Horizontal-first always uses every lane. Vertical-first uses the hint,
// clamped to the lane count, and a hint of 0 counts as one slot.
// Assumes LANES fits in HINT_W bits.
module vstep_width #(
    parameter int LANES  = 4,
    parameter int HINT_W = 7,
    parameter int CNT_W  = 3
) (
    input  logic              vfirst,
    input  logic [HINT_W-1:0] hint,
    output logic [CNT_W-1:0]  width
);
    // Pick the effective issue width.
    always_comb begin
        if (!vfirst) begin
            width = CNT_W'(LANES);
        end else if (hint == '0) begin
            width = CNT_W'(1);
        end else if (hint > HINT_W'(LANES)) begin
            width = CNT_W'(LANES);
        end else begin
            width = CNT_W'(hint);
        end
    end
endmodule

// File: rtl/vstep_lanes.sv
// Module vstep_lanes
// Builds the per-lane slot positions as a chain of single-step incrementers
// starting at the base position. Marks the lanes that fall inside both the
// batch width and the remaining vector. Also returns the position that lies
// `width` sub-elements past the base.
// Assumes width <= LANES.
module vstep_lanes #(
    parameter int LANES  = 4,
    parameter int VL_W   = 7,
    parameter int SUB_W  = 2,
    parameter int CNT_W  = 3,
    parameter int FLAT_W = 9
) (
    input  logic [VL_W-1:0]        base_elem,
    input  logic [SUB_W-1:0]       base_sub,
    input  logic [SUB_W-1:0]       sub_last,
    input  logic [CNT_W-1:0]       width,
    input  logic [FLAT_W-1:0]      rem,
    output logic [LANES-1:0]       lane_valid,
    output logic [LANES*VL_W-1:0]  lane_elem,
    output logic [LANES*SUB_W-1:0] lane_sub,
    output logic [LANES-1:0]       lane_first,
    output logic [VL_W-1:0]        adv_elem,
    output logic [SUB_W-1:0]       adv_sub
);
    logic [VL_W-1:0]  ch_elem [LANES+1];
    logic [SUB_W-1:0] ch_sub  [LANES+1];

    assign ch_elem[0] = base_elem;
    assign ch_sub[0]  = base_sub;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        vstep_inc #(.VL_W(VL_W), .SUB_W(SUB_W)) u_inc (
            .in_elem  (ch_elem[g]),
            .in_sub   (ch_sub[g]),
            .sub_last (sub_last),
            .out_elem (ch_elem[g+1]),
            .out_sub  (ch_sub[g+1])
        );
        assign lane_elem[g*VL_W +: VL_W]   = ch_elem[g];
        assign lane_sub[g*SUB_W +: SUB_W]  = ch_sub[g];
        assign lane_valid[g] = (CNT_W'(g) < width) && (FLAT_W'(g) < rem);
        assign lane_first[g] = (ch_sub[g] == '0);
    end

    // Select the chain tap that lies one batch past the base.
    always_comb begin
        adv_elem = ch_elem[0];
        adv_sub  = ch_sub[0];
        for (int k = 1; k <= LANES; k++) begin
            if (width == CNT_W'(k)) begin
                adv_elem = ch_elem[k];
                adv_sub  = ch_sub[k];
            end
        end
    end
endmodule

// File: rtl/vstep_seq.sv
// Module vstep_seq (top)
// Element step sequencer for one vector instruction. It latches the length,
// sub-vector size, mode and hint on start. It issues up to LANES
// sub-element slots per busy cycle, runs to the end of the vector in
// horizontal-first mode, and issues one fixed batch in vertical-first mode.
// In vertical-first mode the counters move only on an idle-time step request.
// Assumes cfg_vl <= MAXVL and that cfg_* are valid while start is high.
module vstep_seq
    import vstep_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int MAXVL  = 64,
    parameter int HINT_W = 7,
    localparam int VL_W   = $clog2(MAXVL + 1),
    localparam int CNT_W  = $clog2(LANES + 1),
    localparam int FLAT_W = VL_W + SUB_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [VL_W-1:0]        cfg_vl,
    input  logic [1:0]             cfg_subvl,
    input  logic                   cfg_vfirst,
    input  logic [HINT_W-1:0]      cfg_hint,
    input  logic                   step_req,
    output logic                   busy,
    output logic                   done,
    output logic [LANES-1:0]       slot_valid,
    output logic [LANES*VL_W-1:0]  slot_elem,
    output logic [LANES*2-1:0]     slot_sub,
    output logic [LANES-1:0]       slot_grp_first,
    output logic [VL_W-1:0]        srcstep,
    output logic [VL_W-1:0]        dststep,
    output logic [1:0]             svstep
);
    seq_state_t       state_q;
    logic [VL_W-1:0]  vl_q;
    logic [SUB_W-1:0] sub_q;
    logic             vf_q;
    logic [CNT_W-1:0] width_q;
    logic [VL_W-1:0]  elem_q;
    logic [SUB_W-1:0] subpos_q;

    logic [CNT_W-1:0]  width_new;
    logic [FLAT_W-1:0] sub_len;
    logic [FLAT_W-1:0] flat_now;
    logic [FLAT_W-1:0] total;
    logic [FLAT_W-1:0] rem;
    logic              done_c;
    logic [LANES-1:0]  lane_valid;
    logic [LANES-1:0]  lane_first;
    logic [VL_W-1:0]   adv_elem;
    logic [SUB_W-1:0]  adv_sub;

    vstep_width #(.LANES(LANES), .HINT_W(HINT_W), .CNT_W(CNT_W)) u_width (
        .vfirst (cfg_vfirst),
        .hint   (cfg_hint),
        .width  (width_new)
    );

    // Flattened position, vector size and remaining sub-elements.
    always_comb begin
        sub_len  = FLAT_W'(sub_q) + FLAT_W'(1);
        flat_now = FLAT_W'(elem_q) * sub_len + FLAT_W'(subpos_q);
        total    = FLAT_W'(vl_q) * sub_len;
        rem      = (flat_now >= total) ? '0 : (total - flat_now);
    end

    vstep_lanes #(
        .LANES(LANES), .VL_W(VL_W), .SUB_W(SUB_W),
        .CNT_W(CNT_W), .FLAT_W(FLAT_W)
    ) u_lanes (
        .base_elem  (elem_q),
        .base_sub   (subpos_q),
        .sub_last   (sub_q),
        .width      (width_q),
        .rem        (rem),
        .lane_valid (lane_valid),
        .lane_elem  (slot_elem),
        .lane_sub   (slot_sub),
        .lane_first (lane_first),
        .adv_elem   (adv_elem),
        .adv_sub    (adv_sub)
    );

    // Instruction end: the single vertical batch, or the final horizontal one.
    assign busy   = (state_q == ST_RUN);
    assign done_c = busy && (vf_q || (rem <= FLAT_W'(LANES)));
    assign done   = done_c;

    // Gate lane outputs with the busy state.
    assign slot_valid     = lane_valid & {LANES{busy}};
    assign slot_grp_first = lane_first & slot_valid;
    assign srcstep        = elem_q;
    assign dststep        = elem_q;
    assign svstep         = subpos_q;

    // Sequencer state, latched configuration and step counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            vl_q     <= '0;
            sub_q    <= '0;
            vf_q     <= 1'b0;
            width_q  <= CNT_W'(1);
            elem_q   <= '0;
            subpos_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        vl_q    <= cfg_vl;
                        sub_q   <= cfg_subvl;
                        vf_q    <= cfg_vfirst;
                        width_q <= width_new;
                        state_q <= ST_RUN;
                    end else if (step_req && vf_q) begin
                        if (FLAT_W'(width_q) >= rem) begin
                            elem_q   <= '0;
                            subpos_q <= '0;
                        end else begin
                            elem_q   <= adv_elem;
                            subpos_q <= adv_sub;
                        end
                    end
                end
                default: begin
                    if (done_c) begin
                        state_q <= ST_IDLE;
                        if (!vf_q) begin
                            elem_q   <= '0;
                            subpos_q <= '0;
                        end
                    end else if (!vf_q) begin
                        elem_q   <= adv_elem;
                        subpos_q <= adv_sub;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/vstep_seq_chk.sv
// Module vstep_seq_chk
// Temporal checks on the sequencer, attached to every vstep_seq instance.
// Assumes the same reset convention as the design.
module vstep_seq_chk #(
    parameter int LANES = 4,
    parameter int VL_W  = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic             vf,
    input logic [LANES-1:0] slot_valid,
    input logic [VL_W-1:0]  srcstep,
    input logic [1:0]       svstep
);
    // R1
    idle_no_slots_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (slot_valid == '0));

    // R2
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);

    // R3
    lanes_packed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ((slot_valid & (slot_valid + LANES'(1))) == '0));

    // R5
    done_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    // R5
    hf_keeps_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    // R5
    hf_rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && done && !vf) |=> (srcstep == '0) && (svstep == '0) && !busy);

    // R7
    vf_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && vf) |=> (!busy && $stable(srcstep) && $stable(svstep)));
endmodule

bind vstep_seq vstep_seq_chk #(.LANES(LANES), .VL_W(VL_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .busy       (busy),
    .done       (done),
    .vf         (vf_q),
    .slot_valid (slot_valid),
    .srcstep    (srcstep),
    .svstep     (svstep)
);

// File: tb/vstep_seq_tb.sv
`timescale 1ns/1ps
module vstep_seq_tb;
    localparam int LANES  = 4;
    localparam int VL_W   = 7;
    localparam int HINT_W = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [VL_W-1:0] cfg_vl = '0;
    logic [1:0] cfg_subvl = '0;
    logic cfg_vfirst = 1'b0;
    logic [HINT_W-1:0] cfg_hint = '0;
    logic step_req = 1'b0;
    logic busy, done;
    logic [LANES-1:0] slot_valid, slot_grp_first;
    logic [LANES*VL_W-1:0] slot_elem;
    logic [LANES*2-1:0] slot_sub;
    logic [VL_W-1:0] srcstep, dststep;
    logic [1:0] svstep;

    vstep_seq #(.LANES(LANES), .MAXVL(64), .HINT_W(HINT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_vl(cfg_vl),
        .cfg_subvl(cfg_subvl), .cfg_vfirst(cfg_vfirst), .cfg_hint(cfg_hint),
        .step_req(step_req), .busy(busy), .done(done), .slot_valid(slot_valid),
        .slot_elem(slot_elem), .slot_sub(slot_sub),
        .slot_grp_first(slot_grp_first), .srcstep(srcstep), .dststep(dststep),
        .svstep(svstep)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    int pos = 0;
    bit last_vf = 1'b0;
    int last_e = 1;
    int last_total = 0;
    int last_sub = 1;

    // HF table: vl, subvl code, expected busy cycles (R5, R3, R4)
    localparam int TBL [6][3] = '{
        '{5, 0, 2}, '{3, 2, 3}, '{4, 3, 4},
        '{1, 1, 1}, '{64, 3, 64}, '{7, 1, 4}
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic chk_batch(input string tag, input int p, input int n,
                             input int sub, input bit exp_done);
        chk({tag, " R2 busy"}, int'(busy), 1);
        chk({tag, " R5 done"}, int'(done), int'(exp_done));
        for (int i = 0; i < LANES; i++) begin
            bit v;
            v = (i < n);
            chk({tag, " R3 valid"}, int'(slot_valid[i]), int'(v));
            if (v) begin
                chk({tag, " R3 elem"}, int'(slot_elem[i*VL_W +: VL_W]), (p + i) / sub);
                chk({tag, " R3 sub"}, int'(slot_sub[2*i +: 2]), (p + i) % sub);
                chk({tag, " R4 first"}, int'(slot_grp_first[i]), int'(((p + i) % sub) == 0));
            end else begin
                chk({tag, " R4 first idle"}, int'(slot_grp_first[i]), 0);
            end
        end
    endtask

    task automatic chk_pos(input string tag);
        chk({tag, " src"}, int'(srcstep), pos / last_sub);
        chk({tag, " dst"}, int'(dststep), pos / last_sub);
        chk({tag, " sv"}, int'(svstep), pos % last_sub);
    endtask

    task automatic run(input int vl, input int code, input bit vf, input int hint,
                       input bit poke, input bit with_step, input string tag,
                       output int cycles);
        int sub, total, e, rem, n;
        bit d;
        sub = code + 1;
        total = vl * sub;
        e = !vf ? LANES : (hint == 0 ? 1 : (hint > LANES ? LANES : hint));
        @(negedge clk);
        start = 1'b1; cfg_vl = VL_W'(vl); cfg_subvl = 2'(code);
        cfg_vfirst = vf; cfg_hint = HINT_W'(hint); step_req = with_step;
        @(negedge clk);
        start = 1'b0; step_req = 1'b0;
        cycles = 0;
        forever begin
            rem = (pos >= total) ? 0 : total - pos;
            n = (e < rem) ? e : rem;
            d = vf || (rem <= LANES);
            chk_batch(tag, pos, n, sub, d);
            cycles++;
            if (d || cycles > 300) break;
            pos += n;
            if (poke && cycles == 1) begin
                start = 1'b1; cfg_vl = 3; cfg_vfirst = 1'b1; cfg_hint = 1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        if (!vf) pos = 0;
        last_vf = vf; last_e = e; last_total = total; last_sub = sub;
        @(negedge clk);
        chk({tag, " R2 idle after"}, int'(busy), 0);
        chk_pos({tag, " R5/R7 pos after"});
    endtask

    task automatic step(input string tag);
        @(negedge clk);
        step_req = 1'b1;
        @(negedge clk);
        step_req = 1'b0;
        if (last_vf) begin
            pos += last_e;
            if (pos >= last_total) pos = 0;
        end
        chk({tag, " busy"}, int'(busy), 0);
        chk_pos(tag);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog R5: actual hung expected finished");
        summary();
        $finish;
    end

    initial begin
        int cyc;
        repeat (3) @(negedge clk);
        // R1 reset state while reset is held
        chk("R1 busy", int'(busy), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 valid", int'(slot_valid), 0);
        chk("R1 first", int'(slot_grp_first), 0);
        chk_pos("R1 pos");
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy after release", int'(busy), 0);

        // Horizontal-first vector table (R5)
        for (int t = 0; t < 6; t++) begin
            run(TBL[t][0], TBL[t][1], 1'b0, 0, 1'b0, 1'b0, "R5 table", cyc);
            chk("R5 cycles", cyc, TBL[t][2]);
        end

        // R6 zero length in both modes
        run(0, 2, 1'b0, 0, 1'b0, 1'b0, "R6 hf", cyc);
        chk("R6 hf cycles", cyc, 1);
        run(0, 1, 1'b1, 3, 1'b0, 1'b0, "R6 vf", cyc);
        chk("R6 vf cycles", cyc, 1);

        // R7/R8 vertical-first, vl=5, size 2, hint 3
        run(5, 1, 1'b1, 3, 1'b0, 1'b0, "R7 vf a", cyc);
        step("R8 step to 3");
        run(5, 1, 1'b1, 3, 1'b0, 1'b0, "R7 vf b", cyc);
        step("R8 step to 6");
        step("R8 step to 9");
        run(5, 1, 1'b1, 3, 1'b0, 1'b0, "R7 vf clip", cyc);
        step("R8 wrap");

        // R7 hint 0 means one slot
        run(3, 0, 1'b1, 0, 1'b0, 1'b0, "R7 hint0", cyc);
        step("R8 single step");

        // R9 step during the busy cycle is ignored
        @(negedge clk);
        start = 1'b1; cfg_vl = 3; cfg_subvl = 0; cfg_vfirst = 1'b1; cfg_hint = 0;
        @(negedge clk);
        start = 1'b0; step_req = 1'b1;
        chk("R9 busy at step", int'(busy), 1);
        @(negedge clk);
        step_req = 1'b0;
        chk("R9 idle", int'(busy), 0);
        chk_pos("R9 step while busy");

        // R7 hint clamped to lane count
        run(5, 0, 1'b1, 9, 1'b0, 1'b0, "R7 clamp", cyc);
        // R9 start and step together: start wins, no advance
        run(5, 0, 1'b1, 9, 1'b0, 1'b1, "R9 start+step", cyc);

        // R5 horizontal run from a nonzero position, then R9 HF step ignored
        run(3, 0, 1'b0, 0, 1'b0, 1'b0, "R5 hf resume", cyc);
        chk("R5 resume cycles", cyc, 1);
        step("R9 hf step ignored");

        // R10 vertical batch covering the whole vector
        run(2, 1, 1'b1, 4, 1'b0, 1'b0, "R10 vf full", cyc);
        chk("R10 vf cycles", cyc, 1);
        run(2, 1, 1'b0, 0, 1'b0, 1'b0, "R10 hf same", cyc);
        chk("R10 hf cycles", cyc, 1);

        // R5 horizontal run started mid-vector after a vertical step
        run(5, 1, 1'b1, 3, 1'b0, 1'b0, "R5 vf pre", cyc);
        step("R8 step before hf");
        run(5, 1, 1'b0, 0, 1'b0, 1'b0, "R5 hf from 3", cyc);
        chk("R5 cycles from 3", cyc, 2);

        // R2 start while busy is ignored
        run(16, 0, 1'b0, 0, 1'b1, 1'b0, "R2 poke", cyc);
        chk("R2 poke cycles", cyc, 4);

        summary();
        $finish;
    end
endmodule